// File: doc/BRIEF.md
# Byte Programming Controller with Lock Levels

This block is the on-chip side of a parallel programming port for a byte-wide code memory. An external programmer presents an address, a data byte and a two-bit operation code, raises the high-voltage enable and pulses the program strobe. Each accepted pulse starts one self-timed byte write, whose duration is a parameterised number of clock cycles. Progress can be followed in two ways. The ready output stays low while a write runs. A verify read of the address being written returns bit 7 inverted until the write finishes.

Three lock bits raise the protection level step by step. The first blocks further code programming and internal fetches by table reads that run from external memory. The second also blocks verify reads. The third also blocks external execution. The lock bits cannot be read back directly; the programmer sees them only through the features they switch off. A signature read returns three fixed identification bytes. Two resets exist. `erase` wipes the array and the locks. `rst_n` aborts any write in progress and samples the external-access pin, but keeps the locks.

Top module: `byte_prog_ctrl`

## Requirements
- R1: A rising edge on `prog_strobe` with `hv_en` high, `ready` high, `mode`=2'b00 (code write) and lock bit 0 clear writes `din` to `addr`. A later verify read (`rd_en` with `mode`=2'b10) returns that byte in `dout` one cycle after the request.
- R2: `ready` falls on the clock edge that accepts a write. It then stays low for exactly WRITE_CYCLES cycles before rising again.
- R3: While a code write is busy, a verify read of the address being written returns `{~data[7], data[6:0]}`. After completion it returns the true byte.
- R4: A strobe edge is ignored if it arrives while busy, while `hv_en` is low, or with `mode`=2'b10 or 2'b11. An ignored edge leaves the array unchanged and does not extend the busy time.
- R5: A lock write (`mode`=2'b01) sets lock bits when it completes, filling downward. `din[2]` sets all three bits, `din[1]` sets bits 1 and 0, and `din[0]` sets bit 0. Lock bits are never cleared except by `erase`, and `rst_n` keeps them.
- R6: With lock bit 0 set, a code-write strobe is rejected. `lock_err` pulses for one cycle, the array is unchanged, `ready` stays high and `int_fetch_ok` is low.
- R7: With lock bit 1 set, a verify read returns 8'h00 and pulses `lock_err`. With it clear, a verify read returns the array contents and does not raise `lock_err`.
- R8: With lock bit 2 set, `ext_exec_ok` is low. Otherwise it is high.
- R9: The external-access pin is sampled while `rst_n` is low or `erase` is high. `ea_fault` is high when lock bit 0 is set and the sampled value differs from the live pin.
- R10: A read with `mode`=2'b11 and `sig_sel_n`=2'b00 returns 8'h1E at address 000H, 8'h87 at 100H, 8'h05 at 200H and 8'h00 elsewhere. With `sig_sel_n` not 2'b00 it returns 8'h00. Lock bits do not affect this read.
- R11: `erase` sets every array byte to 8'hFF, clears the lock bits, drives `ready` high and clears `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low control reset; keeps the array and the locks |
| erase | input | 1 | Synchronous full-array reset: clears the array and the locks |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data, or lock-bit request for a lock write |
| mode | input | 2 | 00 code write, 01 lock write, 10 verify, 11 signature |
| sig_sel_n | input | 2 | Signature select lines, active low |
| hv_en | input | 1 | High-voltage programming enable |
| prog_strobe | input | 1 | Program strobe; its rising edge starts a write |
| rd_en | input | 1 | Read request for verify or signature |
| ext_access | input | 1 | External-access pin level |
| dout | output | 8 | Read data, registered |
| ready | output | 1 | High when idle, low while a write runs |
| lock_err | output | 1 | One-cycle pulse when a write or verify is refused because of the locks |
| int_fetch_ok | output | 1 | Table reads from external code may fetch internal bytes |
| ext_exec_ok | output | 1 | External execution allowed |
| ea_fault | output | 1 | Sampled external-access level differs from the live pin |

## Verification
The embedded properties check the timing rules on every cycle. They check that `ready` drops right after an accepted strobe, and that a strobe arriving while busy does not restart the countdown. They check that locked writes and locked verifies produce the error pulse, and that bit 7 inverts during polling. They also check that the lock bits never clear without an erase. The exact busy length, the final array contents, the downward fill of the lock bits, the signature values, the external-access comparison and the effect of erase can only be shown by the bench. It does this through random writes and reads compared against a model, followed by directed sequences that step through each lock level.

// File: rtl/byte_prog_ctrl.sv
module byte_prog_ctrl #(
  parameter int ADDR_W       = 10,
  parameter int WRITE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [1:0]        mode,
  input  logic [1:0]        sig_sel_n,
  input  logic              hv_en,
  input  logic              prog_strobe,
  input  logic              rd_en,
  input  logic              ext_access,
  output logic [7:0]        dout,
  output logic              ready,
  output logic              lock_err,
  output logic              int_fetch_ok,
  output logic              ext_exec_ok,
  output logic              ea_fault
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(WRITE_CYCLES + 1);
  localparam logic [1:0] M_CODE = 2'b00;
  localparam logic [1:0] M_LOCK = 2'b01;
  localparam logic [1:0] M_VER  = 2'b10;
  localparam logic [1:0] M_SIG  = 2'b11;

  logic [7:0]        mem [DEPTH];
  logic [2:0]        lb;
  logic              busy;
  logic [CW-1:0]     cnt;
  logic              strobe_q;
  logic [ADDR_W-1:0] p_addr;
  logic [7:0]        p_data;
  logic              p_lock;
  logic              ea_held;

  wire rise      = prog_strobe & ~strobe_q;
  wire req       = rise & hv_en & ~busy & ((mode == M_CODE) | (mode == M_LOCK));
  wire code_blk  = (mode == M_CODE) & lb[0];
  wire start     = req & ~code_blk;
  wire vreq      = rd_en & (mode == M_VER);
  wire done      = busy & (cnt == '0);
  wire poll_hit  = busy & ~p_lock & (addr == p_addr);
  wire [2:0] fill = din[2] ? 3'b111 : din[1] ? 3'b011 : din[0] ? 3'b001 : 3'b000;

  function automatic logic [7:0] sig_byte(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(10'h000))      sig_byte = 8'h1E;
    else if (a == ADDR_W'(10'h100)) sig_byte = 8'h87;
    else if (a == ADDR_W'(10'h200)) sig_byte = 8'h05;
    else                            sig_byte = 8'h00;
  endfunction

  always_ff @(posedge clk) begin
    if (erase || !rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      strobe_q <= 1'b0;
      lock_err <= 1'b0;
      dout     <= 8'h00;
      p_addr   <= '0;
      p_data   <= 8'h00;
      p_lock   <= 1'b0;
      if (erase) lb <= 3'b000;
    end else begin
      strobe_q <= prog_strobe;
      lock_err <= (req & code_blk) | (vreq & lb[1]);
      if (start) begin
        busy   <= 1'b1;
        cnt    <= CW'(WRITE_CYCLES - 1);
        p_addr <= addr;
        p_data <= (mode == M_LOCK) ? {5'b00000, fill} : din;
        p_lock <= (mode == M_LOCK);
      end else if (busy) begin
        if (done) begin
          busy <= 1'b0;
          if (p_lock) lb <= lb | p_data[2:0];
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (rd_en) begin
        case (mode)
          M_VER: begin
            if (lb[1])         dout <= 8'h00;
            else if (poll_hit) dout <= {~p_data[7], p_data[6:0]};
            else               dout <= mem[addr];
          end
          M_SIG:   dout <= (sig_sel_n == 2'b00) ? sig_byte(addr) : 8'h00;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (rst_n && done && !p_lock) begin
      mem[p_addr] <= p_data;
    end
  end

  always_ff @(posedge clk) begin
    if (erase || !rst_n) ea_held <= ext_access;
  end

  assign ready        = ~busy;
  assign int_fetch_ok = ~lb[0];
  assign ext_exec_ok  = ~lb[2];
  assign ea_fault     = lb[0] & (ea_held ^ ext_access);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (erase || !rst_n)
    start |=> !ready);

  // R4
  busy_strobe_ignored_chk: assert property (@(posedge clk) disable iff (erase || !rst_n)
    (rise && busy && cnt != '0) |=> (!ready && cnt == $past(cnt) - 1'b1));

  // R6
  locked_write_chk: assert property (@(posedge clk) disable iff (erase || !rst_n)
    (req && code_blk) |=> (ready && lock_err));

  // R7
  locked_verify_chk: assert property (@(posedge clk) disable iff (erase || !rst_n)
    (vreq && lb[1]) |=> (dout == 8'h00 && lock_err));

  // R3
  poll_bit7_chk: assert property (@(posedge clk) disable iff (erase || !rst_n)
    (vreq && !lb[1] && poll_hit) |=> (dout[7] != $past(p_data[7])));

  // R5
  lock_monotonic_chk: assert property (@(posedge clk) disable iff (erase)
    !erase |=> ((lb & $past(lb)) == $past(lb)));
endmodule

// File: tb/byte_prog_ctrl_bench.sv
module byte_prog_ctrl_bench;
  localparam int CLK_P  = 10;
  localparam int AW     = 10;
  localparam int WC     = 8;
  localparam int DEPTH  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b1, erase = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'h00;
  logic [1:0] mode = 2'b10, sig_sel_n = 2'b11;
  logic hv_en = 1'b0, prog_strobe = 1'b0, rd_en = 1'b0, ext_access = 1'b0;
  logic [7:0] dout;
  logic ready, lock_err, int_fetch_ok, ext_exec_ok, ea_fault;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] ref_mem [DEPTH];
  logic [2:0] ref_lb;

  always #(CLK_P/2) clk = ~clk;

  byte_prog_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC)) u_byte_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .erase(erase), .addr(addr), .din(din), .mode(mode),
    .sig_sel_n(sig_sel_n), .hv_en(hv_en), .prog_strobe(prog_strobe), .rd_en(rd_en),
    .ext_access(ext_access), .dout(dout), .ready(ready), .lock_err(lock_err),
    .int_fetch_ok(int_fetch_ok), .ext_exec_ok(ext_exec_ok), .ea_fault(ea_fault));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_verify(input logic [AW-1:0] a);
    return ref_lb[1] ? 8'h00 : ref_mem[a];
  endfunction

  function automatic logic [7:0] exp_sig(input logic [AW-1:0] a, input logic [1:0] sel);
    if (sel != 2'b00) return 8'h00;
    case (a)
      10'h000: return 8'h1E;
      10'h100: return 8'h87;
      10'h200: return 8'h05;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] exp_fill(input logic [7:0] d);
    return d[2] ? 3'b111 : d[1] ? 3'b011 : d[0] ? 3'b001 : 3'b000;
  endfunction

  task automatic do_erase();
    @(negedge clk); erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    ref_lb = 3'b000;
  endtask

  task automatic wr(input logic [1:0] m, input logic [AW-1:0] a, input logic [7:0] d,
                    input logic hv, output int nbusy, output logic err);
    bit acc;
    acc = hv && (m == 2'b00 || m == 2'b01) && !(m == 2'b00 && ref_lb[0]);
    @(negedge clk); mode = m; addr = a; din = d; hv_en = hv; prog_strobe = 1'b1;
    @(negedge clk); prog_strobe = 1'b0; err = lock_err;
    nbusy = 0;
    while (!ready && nbusy < 1000) begin nbusy++; @(negedge clk); end
    hv_en = 1'b0;
    if (acc && m == 2'b00) ref_mem[a] = d;
    if (acc && m == 2'b01) ref_lb = ref_lb | exp_fill(d);
  endtask

  task automatic rd(input logic [1:0] m, input logic [AW-1:0] a, input logic [1:0] sel,
                    output logic [7:0] d, output logic err);
    @(negedge clk); mode = m; addr = a; sig_sel_n = sel; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = dout; err = lock_err;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int nb;
    logic e;
    logic [7:0] d;
    void'($urandom(32'd20240517));
    repeat (2) @(negedge clk);
    erase = 1'b0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    ref_lb = 3'b000;
    chk("R11 ready after erase", ready, 1);
    chk("R11 dout after erase", dout, 0);
    chk("R8 exec ok after erase", ext_exec_ok, 1);
    rd(2'b10, 10'h2A7, 2'b11, d, e);
    chk("R11 erased byte", d, 8'hFF);

    // R1 R2 random writes and verifies
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 15) * 37);
      if ($urandom_range(0, 1) == 0) begin
        wr(2'b00, a, 8'($urandom), 1'b1, nb, e);
        chk("R2 busy length", nb, WC);
      end else begin
        rd(2'b10, a, 2'b11, d, e);
        chk("R1 verify data", d, exp_verify(a));
        chk("R7 no error when unlocked", e, 0);
      end
    end

    // R3 data polling
    @(negedge clk); mode = 2'b00; addr = 10'h155; din = 8'hA5; hv_en = 1'b1; prog_strobe = 1'b1;
    @(negedge clk); prog_strobe = 1'b0; mode = 2'b10; rd_en = 1'b1;
    chk("R2 ready low after accept", ready, 0);
    @(negedge clk); rd_en = 1'b0;
    chk("R3 polled byte", dout, 8'h25);
    while (!ready) @(negedge clk);
    hv_en = 1'b0; ref_mem[10'h155] = 8'hA5;
    rd(2'b10, 10'h155, 2'b11, d, e);
    chk("R3 true byte after write", d, 8'hA5);

    // R4 strobe during busy ignored, busy not extended
    @(negedge clk); mode = 2'b00; addr = 10'h0C3; din = 8'h3C; hv_en = 1'b1; prog_strobe = 1'b1;
    @(negedge clk); prog_strobe = 1'b0; nb = 1;
    @(negedge clk); nb++; addr = 10'h0C4; din = 8'h11; prog_strobe = 1'b1;
    @(negedge clk); nb++; prog_strobe = 1'b0;
    while (!ready) begin @(negedge clk); if (!ready) nb++; end
    hv_en = 1'b0; ref_mem[10'h0C3] = 8'h3C;
    chk("R4 busy not extended", nb, WC);
    rd(2'b10, 10'h0C4, 2'b11, d, e);
    chk("R4 busy strobe left array", d, ref_mem[10'h0C4]);
    wr(2'b00, 10'h0C5, 8'h77, 1'b0, nb, e);
    chk("R4 no hv no busy", nb, 0);
    rd(2'b10, 10'h0C5, 2'b11, d, e);
    chk("R4 no hv left array", d, ref_mem[10'h0C5]);
    wr(2'b10, 10'h0C5, 8'h77, 1'b1, nb, e);
    chk("R4 read mode strobe ignored", nb, 0);

    // R10 signatures
    rd(2'b11, 10'h000, 2'b00, d, e); chk("R10 sig 000", d, exp_sig(10'h000, 2'b00));
    rd(2'b11, 10'h100, 2'b00, d, e); chk("R10 sig 100", d, exp_sig(10'h100, 2'b00));
    rd(2'b11, 10'h200, 2'b00, d, e); chk("R10 sig 200", d, exp_sig(10'h200, 2'b00));
    rd(2'b11, 10'h100, 2'b01, d, e); chk("R10 sig not selected", d, 8'h00);

    // R5 R6 R9 lock level one
    @(negedge clk); ext_access = 1'b1; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wr(2'b01, 10'h000, 8'h01, 1'b1, nb, e);
    chk("R5 lock write busy", nb, WC);
    chk("R6 fetch blocked", int_fetch_ok, 0);
    chk("R9 ea matches", ea_fault, 0);
    ext_access = 1'b0; #1;
    chk("R9 ea mismatch", ea_fault, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R9 ea resampled", ea_fault, 0);
    chk("R5 locks kept over rst_n", int_fetch_ok, 0);
    wr(2'b00, 10'h155, 8'h00, 1'b1, nb, e);
    chk("R6 locked write error", e, 1);
    chk("R6 locked write not busy", nb, 0);
    rd(2'b10, 10'h155, 2'b11, d, e);
    chk("R6 array unchanged", d, 8'hA5);
    chk("R7 verify allowed level one", e, 0);

    // R7 R8 higher levels
    wr(2'b01, 10'h000, 8'h02, 1'b1, nb, e);
    rd(2'b10, 10'h155, 2'b11, d, e);
    chk("R7 verify blocked data", d, 8'h00);
    chk("R7 verify blocked error", e, 1);
    chk("R8 exec still ok", ext_exec_ok, 1);
    rd(2'b11, 10'h000, 2'b00, d, e); chk("R10 sig under lock", d, 8'h1E);
    wr(2'b01, 10'h000, 8'h04, 1'b1, nb, e);
    chk("R8 exec blocked", ext_exec_ok, 0);

    // R11 erase
    do_erase();
    chk("R11 locks cleared", {int_fetch_ok, ext_exec_ok}, 2'b11);
    rd(2'b10, 10'h155, 2'b11, d, e);
    chk("R11 array erased", d, 8'hFF);
    // R5 downward fill from bit 2 alone
    wr(2'b01, 10'h000, 8'h04, 1'b1, nb, e);
    chk("R5 fill sets bit 0", int_fetch_ok, 0);
    rd(2'b10, 10'h000, 2'b11, d, e);
    chk("R5 fill sets bit 1", e, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule